// File: doc/BRIEF.md
# Timer Buffered Update Controller

This block owns the double-buffered period and compare/capture registers of an up/down timer/counter, together with the counter itself. Software writes new period and compare values into buffer registers. Each buffer carries a valid flag. When the counter reaches its turning point (top when counting up, bottom when counting down) or software issues a force-update command, every buffer whose flag is set is copied into its active register, and that flag is cleared. Active registers therefore change only at a period boundary, never part way through a period.

A lock bit holds back these transfers so that software can stage several buffers and then release them together. A two-bit command field gives one-shot force update, force restart and hard reset. The hard reset is only honoured while the timer is stopped. Control and flag state is reached through paired set/clear addresses. Writing ones to the set address sets the matching bits, and writing ones to the clear address clears them. When input capture is enabled, capture events load the current count into the compare buffers instead, and the valid flags report pending captures.

Top module: `tc_buffer_ctrl`

## Requirements
- R1: After reset the count is 0, the direction is up (0), the active period is all ones, every active compare value and every valid flag is 0, and the control word reads 0.
- R2: Writing the period buffer (address 5) sets flag bit 0, and writing compare buffer i (address 6+i) sets flag bit i+1. No active register changes. The flag word (addresses 2 and 3) reads zero above bit NCC.
- R3: When counting up and the count equals the active period, update_o is high, the next count is 0, each valid buffer is copied into its active register, and its flag clears. Buffers without a valid flag leave their active registers unchanged.
- R4: When counting down and the count is 0, update_o is high, the count reloads from the active period, and the valid buffers transfer.
- R5: While the lock bit (control bit 1) is set and capture mode is off, an UPDATE condition copies nothing and leaves the flags set.
- R6: A write to the control set address (1) with command bits [3:2] = 01 forces an UPDATE condition in that cycle.
- R7: Command 10 sets the count to 0 and the direction to up, and leaves the active registers unchanged.
- R8: Command 11 is ignored while run_i is high. While run_i is low it returns the count, direction, lock, buffers, flags and active registers to their reset values.
- R9: The command bits [3:2] always read as 0.
- R10: Address 1 or 3 sets the control or flag bits written as one, and address 0 or 2 clears them. Control bit 0 is the direction (1 = down). In the same cycle, a software flag write takes priority over a flag change made by hardware.
- R11: With cap_mode_i high, cap_evt_i[i] loads the current count into compare buffer i and sets flag bit i+1, and cap_clr_i[i] clears that flag. An UPDATE condition then transfers only the period buffer, ignores the lock, and leaves the compare flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Timer running; low means the timer is off |
| cap_mode_i | input | 1 | Input capture operation enabled |
| cap_evt_i | input | NCC | Capture event per channel |
| cap_clr_i | input | NCC | Capture flag clear per channel |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | WIDTH | Register write data |
| rd_addr_i | input | ADDR_W | Register read address |
| rd_data_o | output | WIDTH | Register read data (combinational) |
| cnt_o | output | WIDTH | Current count |
| dir_o | output | 1 | Count direction, 1 = down |
| update_o | output | 1 | UPDATE condition this cycle |
| per_o | output | WIDTH | Active period |
| cc_o | output | NCC*WIDTH | Active compare values, channel i at bits i*WIDTH |

## Verification
The bench builds the block with its default parameters: a 16-bit count, four compare channels, a 4-bit address and the capture variant compiled in. Four channels are enough to mix valid and non-valid buffers in a single transfer. The capture variant makes the lock override and the flag behaviour during capture reachable. The period is shrunk to small values through the block's own buffers, so both the top wrap and the bottom reload are reached within a few cycles.

// File: rtl/tcb_pkg.sv
package tcb_pkg;

   typedef enum logic [1:0] {
      CMD_NONE    = 2'b00,
      CMD_UPDATE  = 2'b01,
      CMD_RESTART = 2'b10,
      CMD_HARDRST = 2'b11
   } tcb_cmd_e;

   localparam int ADR_CTRL_CLR = 0;
   localparam int ADR_CTRL_SET = 1;
   localparam int ADR_FLAG_CLR = 2;
   localparam int ADR_FLAG_SET = 3;
   localparam int ADR_COUNT    = 4;
   localparam int ADR_PERBUF   = 5;
   localparam int ADR_CCBUF0   = 6;

   localparam int CTRL_DIR_BIT  = 0;
   localparam int CTRL_LOCK_BIT = 1;
   localparam int CTRL_CMD_LSB  = 2;

endpackage

// File: rtl/tcb_regif.sv
module tcb_regif
   import tcb_pkg::*;
#(
   parameter int W   = 16,
   parameter int NCC = 4,
   parameter int AW  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [W-1:0]      wr_data,
   input  logic [AW-1:0]     rd_addr,
   input  logic              hrst,
   input  logic [W-1:0]      cnt,
   input  logic              dir,
   input  logic [NCC:0]      flags,
   input  logic [W-1:0]      perbuf,
   input  logic [NCC*W-1:0]  ccbuf,
   input  logic [W-1:0]      per,
   input  logic [NCC*W-1:0]  cc,
   output logic              lock,
   output logic              dir_set,
   output logic              dir_clr,
   output logic              cmd_upd,
   output logic              cmd_restart,
   output logic              cmd_hrst,
   output logic [NCC:0]      flag_set,
   output logic [NCC:0]      flag_clr,
   output logic              perbuf_we,
   output logic [NCC-1:0]    ccbuf_we,
   output logic [W-1:0]      rd_data
);

   localparam int A_PER = ADR_CCBUF0 + NCC;
   localparam int A_CC0 = A_PER + 1;

   logic     wr_cs, wr_cc, wr_fs, wr_fc;
   tcb_cmd_e cmd;

   assign wr_cs = wr_en && (wr_addr == AW'(ADR_CTRL_SET));
   assign wr_cc = wr_en && (wr_addr == AW'(ADR_CTRL_CLR));
   assign wr_fs = wr_en && (wr_addr == AW'(ADR_FLAG_SET));
   assign wr_fc = wr_en && (wr_addr == AW'(ADR_FLAG_CLR));

   // commands are issued only through the set address; they are never stored
   assign cmd         = tcb_cmd_e'(wr_data[CTRL_CMD_LSB +: 2]);
   assign cmd_upd     = wr_cs && (cmd == CMD_UPDATE);
   assign cmd_restart = wr_cs && (cmd == CMD_RESTART);
   assign cmd_hrst    = wr_cs && (cmd == CMD_HARDRST);

   assign dir_set  = wr_cs && wr_data[CTRL_DIR_BIT];
   assign dir_clr  = wr_cc && wr_data[CTRL_DIR_BIT];
   assign flag_set = wr_fs ? wr_data[NCC:0] : '0;
   assign flag_clr = wr_fc ? wr_data[NCC:0] : '0;

   assign perbuf_we = wr_en && (wr_addr == AW'(ADR_PERBUF));

   for (genvar i = 0; i < NCC; i++) begin : g_ccwe
      assign ccbuf_we[i] = wr_en && (wr_addr == AW'(ADR_CCBUF0 + i));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock <= 1'b0;
      end else if (hrst) begin
         lock <= 1'b0;
      end else if (wr_cs && wr_data[CTRL_LOCK_BIT]) begin
         lock <= 1'b1;
      end else if (wr_cc && wr_data[CTRL_LOCK_BIT]) begin
         lock <= 1'b0;
      end
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr == AW'(ADR_CTRL_SET) || rd_addr == AW'(ADR_CTRL_CLR)) begin
         rd_data[CTRL_LOCK_BIT] = lock;
         rd_data[CTRL_DIR_BIT]  = dir;
      end
      if (rd_addr == AW'(ADR_FLAG_SET) || rd_addr == AW'(ADR_FLAG_CLR)) begin
         rd_data[NCC:0] = flags;
      end
      if (rd_addr == AW'(ADR_COUNT))  rd_data = cnt;
      if (rd_addr == AW'(ADR_PERBUF)) rd_data = perbuf;
      if (rd_addr == AW'(A_PER))      rd_data = per;
      for (int i = 0; i < NCC; i++) begin
         if (rd_addr == AW'(ADR_CCBUF0 + i)) rd_data = ccbuf[i*W +: W];
         if (rd_addr == AW'(A_CC0 + i))      rd_data = cc[i*W +: W];
      end
   end

   // R9: command field never reads back non-zero
   p_cmd_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == AW'(ADR_CTRL_SET)) |-> (rd_data[CTRL_CMD_LSB +: 2] == 2'b00));

   // R10/R5: a lock set request is visible in the next cycle
   p_lock_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cs && wr_data[CTRL_LOCK_BIT] && !hrst) |=> lock);

endmodule

// File: rtl/tcb_counter.sv
module tcb_counter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic [W-1:0] per,
   input  logic         restart,
   input  logic         hrst,
   input  logic         dir_set,
   input  logic         dir_clr,
   output logic [W-1:0] cnt,
   output logic         dir,
   output logic         at_end
);

   localparam logic [W-1:0] ZERO = '0;
   localparam logic [W-1:0] ONE  = W'(1);

   // UPDATE condition from counting: top when up, bottom when down
   assign at_end = run && (dir ? (cnt == ZERO) : (cnt == per));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= ZERO;
         dir <= 1'b0;
      end else if (hrst || restart) begin
         cnt <= ZERO;
         dir <= 1'b0;
      end else begin
         if (run) begin
            if (at_end)   cnt <= dir ? per : ZERO;
            else if (dir) cnt <= cnt - ONE;
            else          cnt <= cnt + ONE;
         end
         if (dir_set)      dir <= 1'b1;
         else if (dir_clr) dir <= 1'b0;
      end
   end

   p_restart_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cnt == ZERO && !dir));

   p_wrap_at_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (at_end && !dir && !restart && !hrst) |=> (cnt == ZERO));

   p_reload_at_bottom_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (at_end && dir && !restart && !hrst) |=> (cnt == $past(per)));

endmodule

// File: rtl/tcb_buffers.sv
module tcb_buffers #(
   parameter int           W       = 16,
   parameter int           NCC     = 4,
   parameter bit           CAP_EN  = 1'b1,
   parameter logic [W-1:0] PER_RST = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hrst,
   input  logic              upd,
   input  logic              lock,
   input  logic              cap_mode,
   input  logic [W-1:0]      cnt,
   input  logic [W-1:0]      wdata,
   input  logic              perbuf_we,
   input  logic [NCC-1:0]    ccbuf_we,
   input  logic [NCC:0]      flag_set,
   input  logic [NCC:0]      flag_clr,
   input  logic [NCC-1:0]    cap_evt,
   input  logic [NCC-1:0]    cap_clr,
   output logic [W-1:0]      perbuf,
   output logic [NCC*W-1:0]  ccbuf,
   output logic [W-1:0]      per,
   output logic [NCC*W-1:0]  cc,
   output logic [NCC:0]      flags
);

   logic           cap_on;
   logic [NCC-1:0] cap_hit, cap_drop;
   logic           xfer_per, xfer_cc;
   logic           per_flag;
   logic [NCC-1:0] cc_flag;

   if (CAP_EN) begin : g_capture
      assign cap_on   = cap_mode;
      assign cap_hit  = cap_mode ? cap_evt : '0;
      assign cap_drop = cap_mode ? cap_clr : '0;
   end else begin : g_no_capture
      logic unused_cap;
      assign unused_cap = cap_mode ^ (^cap_evt) ^ (^cap_clr);
      assign cap_on   = 1'b0;
      assign cap_hit  = '0;
      assign cap_drop = '0;
   end

   // capture ignores the lock and hands the compare flags to the capture path
   assign xfer_per = upd && (!lock || cap_on);
   assign xfer_cc  = upd && !lock && !cap_on;

   assign flags = {cc_flag, per_flag};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per      <= PER_RST;
         perbuf   <= '0;
         per_flag <= 1'b0;
      end else if (hrst) begin
         per      <= PER_RST;
         perbuf   <= '0;
         per_flag <= 1'b0;
      end else begin
         if (xfer_per && per_flag) per <= perbuf;
         if (perbuf_we)            perbuf <= wdata;
         if (flag_set[0])          per_flag <= 1'b1;
         else if (flag_clr[0])     per_flag <= 1'b0;
         else if (perbuf_we)       per_flag <= 1'b1;
         else if (xfer_per)        per_flag <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cc      <= '0;
         ccbuf   <= '0;
         cc_flag <= '0;
      end else if (hrst) begin
         cc      <= '0;
         ccbuf   <= '0;
         cc_flag <= '0;
      end else begin
         for (int i = 0; i < NCC; i++) begin
            if (xfer_cc && cc_flag[i]) cc[i*W +: W] <= ccbuf[i*W +: W];
            if (ccbuf_we[i])           ccbuf[i*W +: W] <= wdata;
            else if (cap_hit[i])       ccbuf[i*W +: W] <= cnt;
            if (flag_set[i+1])                    cc_flag[i] <= 1'b1;
            else if (flag_clr[i+1])               cc_flag[i] <= 1'b0;
            else if (ccbuf_we[i] || cap_hit[i])   cc_flag[i] <= 1'b1;
            else if (cap_drop[i] || xfer_cc)      cc_flag[i] <= 1'b0;
         end
      end
   end

   p_lock_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && lock && !cap_mode && !hrst) |=> ($stable(per) && $stable(cc)));

   p_flag_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && !lock && !hrst && !perbuf_we && !flag_set[0]) |=> !flags[0]);

   p_capture_sets_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (CAP_EN && cap_mode && cap_evt[0] && !hrst && !flag_clr[1]) |=> flags[1]);

   p_hard_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
      hrst |=> (per == PER_RST && flags == '0));

endmodule

// File: rtl/tc_buffer_ctrl.sv
module tc_buffer_ctrl
   import tcb_pkg::*;
#(
   parameter int               WIDTH      = 16,
   parameter int               NCC        = 4,
   parameter int               ADDR_W     = 4,
   parameter bit               CAPTURE_EN = 1'b1,
   parameter logic [WIDTH-1:0] PER_RESET  = '1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  run_i,
   input  logic                  cap_mode_i,
   input  logic [NCC-1:0]        cap_evt_i,
   input  logic [NCC-1:0]        cap_clr_i,
   input  logic                  wr_en_i,
   input  logic [ADDR_W-1:0]     wr_addr_i,
   input  logic [WIDTH-1:0]      wr_data_i,
   input  logic [ADDR_W-1:0]     rd_addr_i,
   output logic [WIDTH-1:0]      rd_data_o,
   output logic [WIDTH-1:0]      cnt_o,
   output logic                  dir_o,
   output logic                  update_o,
   output logic [WIDTH-1:0]      per_o,
   output logic [NCC*WIDTH-1:0]  cc_o
);

   localparam int NREGS = ADR_CCBUF0 + 2 * NCC + 1;

   initial begin
      a_width_ok: assert (WIDTH >= 8 && WIDTH <= 32);
      a_ncc_ok:   assert (NCC >= 1 && NCC <= 4);
      a_addr_ok:  assert ((1 << ADDR_W) >= NREGS);
   end

   logic                 lock, dir_set, dir_clr;
   logic                 cmd_upd, cmd_restart, cmd_hrst, hrst_go;
   logic [NCC:0]         flag_set, flag_clr, flags;
   logic                 perbuf_we;
   logic [NCC-1:0]       ccbuf_we;
   logic [WIDTH-1:0]     perbuf;
   logic [NCC*WIDTH-1:0] ccbuf;
   logic                 at_end, upd;

   // a hard reset only applies while the timer is off
   assign hrst_go  = cmd_hrst && !run_i;
   assign upd      = at_end || cmd_upd;
   assign update_o = upd;

   tcb_regif #(.W(WIDTH), .NCC(NCC), .AW(ADDR_W)) u_regif (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en_i), .wr_addr(wr_addr_i), .wr_data(wr_data_i),
      .rd_addr(rd_addr_i), .hrst(hrst_go),
      .cnt(cnt_o), .dir(dir_o), .flags(flags),
      .perbuf(perbuf), .ccbuf(ccbuf), .per(per_o), .cc(cc_o),
      .lock(lock), .dir_set(dir_set), .dir_clr(dir_clr),
      .cmd_upd(cmd_upd), .cmd_restart(cmd_restart), .cmd_hrst(cmd_hrst),
      .flag_set(flag_set), .flag_clr(flag_clr),
      .perbuf_we(perbuf_we), .ccbuf_we(ccbuf_we), .rd_data(rd_data_o)
   );

   tcb_counter #(.W(WIDTH)) u_counter (
      .clk(clk), .rst_n(rst_n), .run(run_i), .per(per_o),
      .restart(cmd_restart), .hrst(hrst_go),
      .dir_set(dir_set), .dir_clr(dir_clr),
      .cnt(cnt_o), .dir(dir_o), .at_end(at_end)
   );

   tcb_buffers #(.W(WIDTH), .NCC(NCC), .CAP_EN(CAPTURE_EN), .PER_RST(PER_RESET)) u_buffers (
      .clk(clk), .rst_n(rst_n), .hrst(hrst_go), .upd(upd), .lock(lock),
      .cap_mode(cap_mode_i), .cnt(cnt_o), .wdata(wr_data_i),
      .perbuf_we(perbuf_we), .ccbuf_we(ccbuf_we),
      .flag_set(flag_set), .flag_clr(flag_clr),
      .cap_evt(cap_evt_i), .cap_clr(cap_clr_i),
      .perbuf(perbuf), .ccbuf(ccbuf), .per(per_o), .cc(cc_o), .flags(flags)
   );

   p_hrst_ignored_running_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_hrst && run_i && !cmd_upd) |=> $stable(per_o));

endmodule

// File: tb/test_tc_buffer_ctrl.sv
module test_tc_buffer_ctrl;

   localparam int W   = 16;
   localparam int NCC = 4;
   localparam int AW  = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            run_i = 1'b0;
   logic            cap_mode_i = 1'b0;
   logic [NCC-1:0]  cap_evt_i = '0;
   logic [NCC-1:0]  cap_clr_i = '0;
   logic            wr_en_i = 1'b0;
   logic [AW-1:0]   wr_addr_i = '0;
   logic [W-1:0]    wr_data_i = '0;
   logic [AW-1:0]   rd_addr_i = '0;
   logic [W-1:0]    rd_data_o, cnt_o, per_o;
   logic            dir_o, update_o;
   logic [NCC*W-1:0] cc_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   tc_buffer_ctrl #(.WIDTH(W), .NCC(NCC), .ADDR_W(AW)) i_tc_buffer_ctrl (
      .clk(clk), .rst_n(rst_n), .run_i(run_i), .cap_mode_i(cap_mode_i),
      .cap_evt_i(cap_evt_i), .cap_clr_i(cap_clr_i),
      .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
      .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
      .cnt_o(cnt_o), .dir_o(dir_o), .update_o(update_o),
      .per_o(per_o), .cc_o(cc_o)
   );

   task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr(input int a, input logic [W-1:0] d);
      @(negedge clk);
      wr_en_i = 1'b1; wr_addr_i = AW'(a); wr_data_i = d;
      @(negedge clk);
      wr_en_i = 1'b0;
   endtask

   task automatic chk_rd(input string tag, input int a, input logic [W-1:0] exp);
      rd_addr_i = AW'(a);
      #1;
      check(tag, 64'(rd_data_o), 64'(exp));
   endtask

   task automatic t_reset;
      check("R1 count", 64'(cnt_o), 64'h0);
      check("R1 dir", 64'(dir_o), 64'h0);
      check("R1 period", 64'(per_o), 64'hFFFF);
      check("R1 compare", 64'(cc_o), 64'h0);
      chk_rd("R1 flags", 3, 16'h0);
      chk_rd("R1 ctrl", 1, 16'h0);
   endtask

   task automatic t_bufwrite;
      wr(5, 16'd5);
      wr(6, 16'd3);
      wr(8, 16'd7);
      chk_rd("R2 flags", 3, 16'h000B);
      chk_rd("R2 perbuf", 5, 16'd5);
      check("R2 active untouched", 64'(per_o), 64'hFFFF);
   endtask

   task automatic t_force;
      wr(1, 16'h0004);
      check("R6 period", 64'(per_o), 64'd5);
      check("R6 compare", 64'(cc_o), {16'h0, 16'd7, 16'h0, 16'd3});
      chk_rd("R6 flags cleared", 2, 16'h0);
      chk_rd("R9 cmd reads zero", 1, 16'h0);
   endtask

   task automatic t_lock;
      wr(1, 16'h0002);
      chk_rd("R10 lock set", 1, 16'h0002);
      wr(5, 16'd9);
      wr(1, 16'h0004);
      check("R5 period held", 64'(per_o), 64'd5);
      chk_rd("R5 flag kept", 3, 16'h0001);
      wr(0, 16'h0002);
      chk_rd("R10 lock clear", 0, 16'h0);
   endtask

   task automatic t_top;
      bit hit = 1'b0;
      wr(7, 16'd4);
      @(negedge clk);
      run_i = 1'b1;
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         if (cnt_o == 16'd3) check("R3 no update mid-period", 64'(update_o), 64'h0);
         if (cnt_o == 16'd5) begin hit = 1'b1; break; end
      end
      check("R3 reached top", 64'(hit), 64'h1);
      check("R3 update at top", 64'(update_o), 64'h1);
      @(negedge clk);
      run_i = 1'b0;
      check("R3 wrap", 64'(cnt_o), 64'h0);
      check("R3 period moved", 64'(per_o), 64'd9);
      check("R3 compare moved", 64'(cc_o), {16'h0, 16'd7, 16'd4, 16'd3});
      chk_rd("R3 flags cleared", 3, 16'h0);
   endtask

   task automatic t_down;
      wr(1, 16'h0001);
      check("R10 dir down", 64'(dir_o), 64'h1);
      wr(9, 16'h0022);
      run_i = 1'b1;
      #1;
      check("R4 update at bottom", 64'(update_o), 64'h1);
      @(negedge clk);
      run_i = 1'b0;
      check("R4 reload", 64'(cnt_o), 64'd9);
      check("R4 compare moved", 64'(cc_o), {16'h22, 16'd7, 16'd4, 16'd3});
   endtask

   task automatic t_restart;
      wr(1, 16'h0008);
      check("R7 count", 64'(cnt_o), 64'h0);
      check("R7 dir", 64'(dir_o), 64'h0);
      check("R7 period kept", 64'(per_o), 64'd9);
   endtask

   task automatic t_hrst;
      wr(1, 16'h0002);
      wr(5, 16'd2);
      run_i = 1'b1;
      wr(1, 16'h000C);
      run_i = 1'b0;
      check("R8 ignored while running", 64'(per_o), 64'd9);
      chk_rd("R8 flags kept", 3, 16'h0001);
      chk_rd("R8 lock kept", 1, 16'h0002);
      wr(1, 16'h000C);
      check("R8 period reset", 64'(per_o), 64'hFFFF);
      check("R8 count reset", 64'(cnt_o), 64'h0);
      check("R8 compare reset", 64'(cc_o), 64'h0);
      chk_rd("R8 flags reset", 3, 16'h0);
      chk_rd("R8 lock reset", 1, 16'h0);
   endtask

   task automatic t_setclr;
      wr(3, 16'h0011);
      chk_rd("R10 flag set", 3, 16'h0011);
      wr(2, 16'h0001);
      chk_rd("R10 flag clear", 3, 16'h0010);
      cap_mode_i = 1'b1;
      @(negedge clk);
      cap_evt_i = 4'b0001;
      wr_en_i = 1'b1; wr_addr_i = AW'(2); wr_data_i = 16'h0002;
      @(negedge clk);
      cap_evt_i = '0; wr_en_i = 1'b0;
      chk_rd("R10 software wins", 3, 16'h0010);
      wr(2, 16'h0010);
      chk_rd("R10 flags empty", 3, 16'h0);
   endtask

   task automatic t_capture;
      cap_mode_i = 1'b1;
      run_i = 1'b1;
      repeat (6) @(negedge clk);
      run_i = 1'b0;
      check("R11 count", 64'(cnt_o), 64'd6);
      cap_evt_i = 4'b0100;
      @(negedge clk);
      cap_evt_i = '0;
      chk_rd("R11 captured value", 8, 16'd6);
      chk_rd("R11 capture flag", 3, 16'h0008);
      wr(5, 16'h0030);
      wr(1, 16'h0002);
      wr(1, 16'h0004);
      check("R11 lock ignored", 64'(per_o), 64'h30);
      check("R11 compare kept", 64'(cc_o), 64'h0);
      chk_rd("R11 cc flag survives", 3, 16'h0008);
      cap_clr_i = 4'b0100;
      @(negedge clk);
      cap_clr_i = '0;
      chk_rd("R11 flag cleared", 3, 16'h0);
      wr(0, 16'h0002);
      cap_mode_i = 1'b0;
   endtask

   initial begin
      for (int c = 0; c < 100000; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_bufwrite();
      t_force();
      t_lock();
      t_top();
      t_down();
      t_restart();
      t_hrst();
      t_setclr();
      t_capture();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule